// File: doc/BRIEF.md
# System Reset Controller

This block gathers every source that can reset a small single-processor system and turns each into properly timed reset pulses. Three of the sources are asynchronous level inputs: a power-on indication, a full-system push-button and a push-button that requests an externally initiated reset (XIR) of the processor alone. The fourth source is software, which requests resets by writing a register. Every asynchronous input passes through a two-flop synchroniser, and only its rising edge is used.

Three reset outputs leave the block. One goes to the processor. One goes to the I/O bridge. The third is the XIR line, which only the processor receives. Power-on and the system button pulse both the processor and bridge resets. The XIR button pulses only the XIR line. Software can pick any combination of the three.

Each pulse lasts a number of clocks that software can program. A status field records which kinds of event caused resets. Software reads it and clears its bits by writing ones to them.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `rst` is high, `cpu_rst_o` and `io_rst_o` are 1 and `xir_o` is 0. The status field reads 0 and the pulse-length register reads `HOLD_DEFAULT` (16).
- R2: Each asynchronous input is synchronised through two flops and edge-detected. A rising input asserts its outputs on the third rising clock edge after the change, and no earlier. An input held high triggers only once, and a falling input has no effect.
- R3: A power-on rising edge pulses `cpu_rst_o` and `io_rst_o`, and leaves `xir_o` low.
- R4: A rising edge on the system button pulses `cpu_rst_o` and `io_rst_o`, and leaves `xir_o` low.
- R5: A rising edge on the XIR button pulses `xir_o` only.
- R6: A triggered output stays high for exactly max(L,1) clocks, where L is the value of the pulse-length register when the trigger occurs. A new trigger during a pulse restarts the count from L.
- R7: Register map. Address 0 read: bits [7:4] are status (bit 4 power-on, bit 5 system button, bit 6 XIR button, bit 7 software), and bits [3:0] read 0. Address 1: an 8-bit pulse length, readable and writable.
- R8: A power-on event clears all status bits and sets only bit 4.
- R9: A button event sets its own status bit and leaves the other status bits unchanged.
- R10: Writing address 0 with a 1 in any of bits [7:4] clears that status bit. If a set of the same bit happens in the same cycle, the set wins.
- R11: Writing address 0 with bit 0, 1 or 2 set requests a processor, bridge or XIR reset respectively. The output is asserted in the cycle after the write, and status bit 7 is set when any of those bits is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_on_i | input | 1 | Asynchronous power-on indication |
| por_btn_i | input | 1 | Asynchronous system reset button |
| xir_btn_i | input | 1 | Asynchronous XIR button |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| cpu_rst_o | output | 1 | Processor reset |
| io_rst_o | output | 1 | I/O bridge reset |
| xir_o | output | 1 | Processor-only XIR reset |

## Verification
The bench sweeps the pulse length over 0, 1, 2, 3 and 7. At each length it fires every hardware source and all seven software request masks, and counts the high cycles on each output. This separates the per-source routing from the length arithmetic, including the zero-length case.

The asynchronous sources are also checked at the edge where their outputs first rise, and with an input held high or dropped. These cases separate correct edge detection from level sensing.

A fixed chain of events then walks the status field: button events, a power-on event, write-one clears, and a clear that collides with a set. A software retrigger in the middle of a pulse shows whether the counter restarts or merely continues.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;
  // output slots
  localparam int OUT_CPU = 0;
  localparam int OUT_IO  = 1;
  localparam int OUT_XIR = 2;
  localparam int NUM_OUT = 3;
  // asynchronous source slots
  localparam int SRC_PWR = 0;
  localparam int SRC_POR = 1;
  localparam int SRC_XIR = 2;
  localparam int NUM_SRC = 3;
  // status bits (cause log), placed at STAT_LSB in the control word
  localparam int ST_PWR  = 0;
  localparam int ST_POR  = 1;
  localparam int ST_XIR  = 2;
  localparam int ST_SW   = 3;
  localparam int NUM_ST  = 4;
  localparam int STAT_LSB = 4;
  // addresses
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_HOLD = 1'b1;
  typedef logic [NUM_ST-1:0] cause_t;
endpackage

// File: rtl/rstc_sync_edge.sv
`timescale 1ns/1ps
module rstc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~prev;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o) else $error("edge pulse longer than one cycle"); // R2
endmodule

// File: rtl/rstc_stretch.sv
`timescale 1ns/1ps
module rstc_stretch #(
  parameter int               CNT_W    = 8,
  parameter bit               INIT_ON  = 1'b0,
  parameter logic [CNT_W-1:0] INIT_CNT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             rst_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= INIT_ON ? INIT_CNT : '0;
      rst_o <= INIT_ON;
    end else if (trig_i) begin
      cnt   <= len_i;
      rst_o <= 1'b1;
    end else begin
      rst_o <= (cnt > ONE);
      if (cnt != '0) cnt <= cnt - ONE;
    end
  end

  AST_CNT_IMPLIES_OUT: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> rst_o) else $error("count pending but output low"); // R6
  AST_FALL_DRAINED: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> (cnt == '0)) else $error("output released early"); // R6
endmodule

// File: rtl/rstc_regs.sv
`timescale 1ns/1ps
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int               DW           = 8,
  parameter int               HOLD_W       = 8,
  parameter logic [HOLD_W-1:0] HOLD_DEFAULT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  cause_t            set_i,
  output logic [DW-1:0]     rdata_o,
  output logic [HOLD_W-1:0] hold_o
);
  cause_t status;
  cause_t clr;
  logic   wr_ctrl;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign clr     = wr_ctrl ? wdata_i[STAT_LSB +: NUM_ST] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      hold_o <= HOLD_DEFAULT;
    end else begin
      if (set_i[ST_PWR]) status <= cause_t'(1) << ST_PWR;
      else               status <= (status & ~clr) | set_i;
      if (wr_i && addr_i == ADDR_HOLD) hold_o <= wdata_i[HOLD_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) rdata_o[STAT_LSB +: NUM_ST] = status;
    else                     rdata_o[HOLD_W-1:0]        = hold_o;
  end

  AST_PWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    set_i[ST_PWR] |=> (status == (cause_t'(1) << ST_PWR))) else $error("power-on log"); // R8
  AST_W1C_POR: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata_i[STAT_LSB+ST_POR] && !set_i[ST_POR] && !set_i[ST_PWR])
      |=> !status[ST_POR]) else $error("write-one clear"); // R10
  AST_BTN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (set_i[ST_XIR] && !set_i[ST_PWR] && !wr_ctrl && status[ST_POR])
      |=> status[ST_POR] && status[ST_XIR]) else $error("button log"); // R9
endmodule

// File: rtl/sys_reset_ctrl.sv
`timescale 1ns/1ps
module sys_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int               DW           = 8,
  parameter int               HOLD_W       = 8,
  parameter logic [HOLD_W-1:0] HOLD_DEFAULT = 16,
  parameter int               SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_on_i,
  input  logic          por_btn_i,
  input  logic          xir_btn_i,
  input  logic          reg_wr_i,
  input  logic          reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          cpu_rst_o,
  output logic          io_rst_o,
  output logic          xir_o
);
  localparam logic [NUM_OUT-1:0] INIT_ON = 3'b011;

  logic [NUM_SRC-1:0] async_in;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_OUT-1:0] sw_req;
  logic [NUM_OUT-1:0] trig;
  logic [NUM_OUT-1:0] rst_vec;
  logic [HOLD_W-1:0]  hold;
  logic               sw_wr;
  cause_t             cause_set;

  assign async_in[SRC_PWR] = pwr_on_i;
  assign async_in[SRC_POR] = por_btn_i;
  assign async_in[SRC_XIR] = xir_btn_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
    rstc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_i(async_in[s]), .rise_o(evt[s]));
  end

  assign sw_wr  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign sw_req = sw_wr ? reg_wdata_i[NUM_OUT-1:0] : '0;

  assign trig[OUT_CPU] = evt[SRC_PWR] | evt[SRC_POR] | sw_req[OUT_CPU];
  assign trig[OUT_IO]  = evt[SRC_PWR] | evt[SRC_POR] | sw_req[OUT_IO];
  assign trig[OUT_XIR] = evt[SRC_XIR] | sw_req[OUT_XIR];

  assign cause_set[ST_PWR] = evt[SRC_PWR];
  assign cause_set[ST_POR] = evt[SRC_POR];
  assign cause_set[ST_XIR] = evt[SRC_XIR];
  assign cause_set[ST_SW]  = |sw_req;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    rstc_stretch #(
      .CNT_W(HOLD_W), .INIT_ON(INIT_ON[o]), .INIT_CNT(HOLD_DEFAULT)
    ) u_stretch (
      .clk(clk), .rst(rst), .trig_i(trig[o]), .len_i(hold), .rst_o(rst_vec[o]));
  end

  rstc_regs #(.DW(DW), .HOLD_W(HOLD_W), .HOLD_DEFAULT(HOLD_DEFAULT)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .set_i(cause_set), .rdata_o(reg_rdata_o), .hold_o(hold));

  assign cpu_rst_o = rst_vec[OUT_CPU];
  assign io_rst_o  = rst_vec[OUT_IO];
  assign xir_o     = rst_vec[OUT_XIR];

  AST_XIR_PATH: assert property (@(posedge clk) disable iff (rst)
    evt[SRC_XIR] |=> xir_o) else $error("xir button not routed"); // R5
  AST_POR_PATH: assert property (@(posedge clk) disable iff (rst)
    evt[SRC_POR] |=> (cpu_rst_o && io_rst_o)) else $error("button not routed"); // R4
  AST_PWR_PATH: assert property (@(posedge clk) disable iff (rst)
    evt[SRC_PWR] |=> (cpu_rst_o && io_rst_o)) else $error("power-on not routed"); // R3
  AST_SW_PATH: assert property (@(posedge clk) disable iff (rst)
    sw_req[OUT_IO] |=> io_rst_o) else $error("software request lost"); // R11
endmodule

// File: tb/tb_sys_reset_ctrl.sv
`timescale 1ns/1ps
module tb_sys_reset_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_on_i = 1'b0, por_btn_i = 1'b0, xir_btn_i = 1'b0;
  logic       reg_wr_i = 1'b0, reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       cpu_rst_o, io_rst_o, xir_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  localparam int WIN = 30;

  always #2.5 clk = ~clk;

  sys_reset_ctrl dut (
    .clk(clk), .rst(rst), .pwr_on_i(pwr_on_i), .por_btn_i(por_btn_i),
    .xir_btn_i(xir_btn_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .cpu_rst_o(cpu_rst_o), .io_rst_o(io_rst_o), .xir_o(xir_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {29'd0, xir_o, io_rst_o, cpu_rst_o};
  endfunction

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic reg_read(input logic a, output int v);
    @(negedge clk); reg_addr_i = a; #1; v = reg_rdata_o;
  endtask

  task automatic set_src(input int s, input logic v);
    case (s)
      0: pwr_on_i = v;
      1: por_btn_i = v;
      default: xir_btn_i = v;
    endcase
  endtask

  // count high samples per output over WIN negedges, first sample already aligned
  task automatic count_win(input int mask, input int hold, input int drop_src,
                           input string req);
    int c0 = 0, c1 = 0, c2 = 0;
    int e = (hold == 0) ? 1 : hold;
    for (int i = 0; i < WIN; i++) begin
      if (i > 0) @(negedge clk);
      c0 += int'(cpu_rst_o); c1 += int'(io_rst_o); c2 += int'(xir_o);
      if (i == 2 && drop_src >= 0) set_src(drop_src, 1'b0);
    end
    chk({req, " cpu"}, c0, mask[0] ? e : 0);
    chk({req, " io"},  c1, mask[1] ? e : 0);
    chk({req, " xir"}, c2, mask[2] ? e : 0);
  endtask

  task automatic fire_async(input int s, input int mask, input int hold,
                            input bit drop, input string req);
    @(negedge clk); set_src(s, 1'b1);
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk({req, " R2 latency"}, outs(), 0);
    @(negedge clk);
    count_win(mask, hold, drop ? s : -1, req);
  endtask

  task automatic fire_sw(input int mask, input int hold, input string req);
    @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 8'(mask);
    @(negedge clk); reg_wr_i = 1'b0; reg_wdata_i = '0;
    count_win(mask, hold, -1, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int holds[5] = '{0, 1, 2, 3, 7};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 outputs", outs(), 3);
    reg_addr_i = 1'b0; #1; chk("R1 status", reg_rdata_o, 0);
    reg_addr_i = 1'b1; #1; chk("R1 hold", reg_rdata_o, 16);
    @(negedge clk); rst = 1'b0;
    repeat (25) @(negedge clk);
    chk("R1 release", outs(), 0);

    foreach (holds[k]) begin
      reg_write(1'b1, 8'(holds[k]));
      reg_read(1'b1, v); chk("R7 hold readback", v, holds[k]);
      fire_async(0, 3, holds[k], 1'b1, "R3 R6 power-on");
      fire_async(1, 3, holds[k], 1'b1, "R4 R6 button");
      fire_async(2, 4, holds[k], 1'b1, "R5 R6 xir");
      for (int m = 1; m < 8; m++) fire_sw(m, holds[k], "R11 R6 software");
    end

    // R2: held input triggers once, falling edge has no effect
    reg_write(1'b1, 8'd4);
    fire_async(1, 3, 4, 1'b0, "R2 held high");
    @(negedge clk); por_btn_i = 1'b0;
    count_win(0, 4, -1, "R2 falling");

    // R6 retrigger: second request 3 cycles into a 6-cycle pulse
    reg_write(1'b1, 8'd6);
    begin
      int c = 0;
      @(negedge clk); reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 8'h01;
      @(negedge clk); reg_wr_i = 1'b0; reg_wdata_i = '0;
      for (int i = 0; i < WIN; i++) begin
        if (i > 0) @(negedge clk);
        if (i == 3) begin reg_wr_i = 1'b0; reg_wdata_i = '0; end
        c += int'(cpu_rst_o);
        if (i == 2) begin reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 8'h01; end
      end
      chk("R6 retrigger", c, 9);
    end

    // status log sequence
    reg_write(1'b0, 8'hF0);
    reg_read(1'b0, v); chk("R10 clear all", v, 8'h00);
    fire_async(1, 3, 6, 1'b1, "R4 status run");
    reg_read(1'b0, v); chk("R9 button bit", v, 8'h20);
    fire_async(2, 4, 6, 1'b1, "R5 status run");
    reg_read(1'b0, v); chk("R9 xir keeps button", v, 8'h60);
    fire_sw(1, 6, "R11 status run");
    reg_read(1'b0, v); chk("R11 software bit", v, 8'hE0);
    fire_async(0, 3, 6, 1'b1, "R3 status run");
    reg_read(1'b0, v); chk("R8 power-on clears", v, 8'h10);
    fire_sw(8'h81, 6, "R10 set wins run");
    reg_read(1'b0, v); chk("R10 set wins", v, 8'h90);
    reg_write(1'b0, 8'h10);
    reg_read(1'b0, v); chk("R10 clear one", v, 8'h80);
    reg_write(1'b0, 8'h80);
    reg_read(1'b0, v); chk("R10 clear last", v, 8'h00);
    reg_read(1'b1, v); chk("R7 hold kept", v, 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule